// File: doc/BRIEF.md
# Lamp Ballast Mode Sequencer

This block is the control state machine of a dimmable fluorescent ballast. It receives digitised comparator flags from analog circuitry outside it: two supply-threshold flags, two line-sense flags, a shutdown flag, an over-temperature flag, an over-current flag and two ignition-detect level flags. From these flags it steps the lamp through five operating modes: lockout, filament preheat, ignition ramp, closed-loop dimming and a latched fault.

The outputs drive the surrounding analog and driver logic. A 3-bit mode code tells the oscillator what to do. A driver enable gates the half-bridge. An over-current enable arms the hard-switching trip. A reference-select line picks the level used for peak-current regulation: the programmable preheat level, or the fixed higher level used during ignition.

Every flag is asynchronous to the block clock, so each one passes through a synchroniser before the mode logic uses it. Preheat length is a parameter measured in clock cycles. Ignition is recognised in two steps. The sense level must first rise above an arming level and then fall below a lower detect level. A fault stays in force until the supply dips or the shutdown input goes high and then low again.

Top module: `ballast_seq`

## Requirements
- R1: While reset is asserted and right after it is released, mode_o is 0 (lockout) and drv_en_o, oc_en_o and ref_hi_o are all 0.
- R2: Lockout moves to preheat (mode 1) only when supply_on_i and line_ok_i are high and shutdown_i and overtemp_i are low, all in the same synchronised sample. Lockout never moves to any other mode.
- R3: From preheat, ignition or dim, the block returns to lockout when supply_off_i, line_low_i or shutdown_i is high. This return takes priority over every other transition.
- R4: Preheat lasts exactly PH_CYCLES clock cycles and then moves to ignition (mode 2). Ignition is entered from preheat only.
- R5: overcur_i has no effect during preheat. oc_en_o is high only in ignition and dim.
- R6: A high overcur_i or overtemp_i in ignition or dim, or a high overtemp_i in preheat, moves the block to fault (mode 4).
- R7: In ignition, detection is armed when sense_arm_i is high. After arming, a high sense_det_i moves the block to dim (mode 3). A high sense_det_i with no earlier arming has no effect. Dim is entered from ignition only.
- R8: ref_hi_o is 0 in preheat (programmable reference) and 1 in ignition (fixed higher level).
- R9: In fault the drivers are off and the mode is held whatever the start flags show. Fault leaves only to lockout: on a high supply_off_i, or when shutdown_i goes high and then low. Any restart then passes through preheat.
- R10: mode_o encodes 0 lockout, 1 preheat, 2 ignition, 3 dim and 4 fault. drv_en_o is high exactly in modes 1, 2 and 3.
- R11: A flag change applied before a clock edge affects mode_o after the third rising edge. The delay comes from two synchroniser stages plus the mode register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_on_i | input | 1 | Supply is above its turn-on threshold |
| supply_off_i | input | 1 | Supply is below its turn-off threshold |
| line_ok_i | input | 1 | Line sense is above its turn-on level |
| line_low_i | input | 1 | Line sense is below its brown-out level |
| shutdown_i | input | 1 | Shutdown comparator is high (lamp fault or removal) |
| overtemp_i | input | 1 | Die temperature is above its limit |
| overcur_i | input | 1 | Sense level is above the over-current threshold |
| sense_arm_i | input | 1 | Sense level is above the preheat reference plus 20 % |
| sense_det_i | input | 1 | Sense level is below the preheat reference plus 10 % |
| mode_o | output | 3 | Mode code (see R10) |
| drv_en_o | output | 1 | Half-bridge driver enable |
| oc_en_o | output | 1 | Over-current trip enable |
| ref_hi_o | output | 1 | Current-regulation reference select: 0 programmable, 1 fixed high |

## Verification
The assertions check several properties on every cycle. They confirm the legal mode transitions: lockout leads only to preheat, ignition is reached only from preheat, dim only from ignition, and fault only to lockout. They also confirm that the drivers are off in lockout and fault, that the over-current enable and reference select are low in preheat, and that the mode code stays in range. Other behaviours depend on input history and timing, so only the bench scenarios can show them. These are the exact preheat length, the synchroniser latency, the two-step ignition detect (including a detect level with no arming), the shutdown high-then-low release from fault, and the priority of brown-out over fault. A behavioural reference model, compared on every clock, covers these.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic [2:0] {
    MD_LOCK = 3'd0,
    MD_PRE  = 3'd1,
    MD_IGN  = 3'd2,
    MD_DIM  = 3'd3,
    MD_FLT  = 3'd4
  } bsq_mode_e;

  localparam int FLAG_N  = 9;
  localparam int FI_VON  = 0;
  localparam int FI_VOFF = 1;
  localparam int FI_LOK  = 2;
  localparam int FI_LLOW = 3;
  localparam int FI_SD   = 4;
  localparam int FI_OT   = 5;
  localparam int FI_OC   = 6;
  localparam int FI_ARM  = 7;
  localparam int FI_DET  = 8;

endpackage

// File: rtl/bsq_rst_sync.sv
module bsq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/bsq_sync.sv
module bsq_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/bsq_timer.sv
module bsq_timer #(
  parameter int TERM = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic cnt_en_i,
  output logic done_o
);

  localparam int CW = (TERM > 1) ? $clog2(TERM) : 1;
  localparam logic [CW-1:0] LAST = CW'(TERM - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)        cnt_d = '0;
    else if (cnt_en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = !load_i && (cnt_q == LAST);

endmodule

// File: rtl/bsq_ign_arm.sv
module bsq_ign_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic arm_lvl_i,
  input  logic det_lvl_i,
  output logic ignited_o
);

  logic armed_q, armed_d;

  always_comb begin
    if (clr_i) armed_d = 1'b0;
    else       armed_d = armed_q | arm_lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign ignited_o = armed_q && det_lvl_i && !clr_i;

endmodule

// File: rtl/bsq_fsm.sv
module bsq_fsm
  import bsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] flg_i,
  input  logic              ph_done_i,
  input  logic              ignited_i,
  output bsq_mode_e         mode_o
);

  bsq_mode_e mode_q, mode_d;
  logic      sd_seen_q, sd_seen_d;
  logic      start_ok, drop, trip;

  always_comb begin
    start_ok  = flg_i[FI_VON] && flg_i[FI_LOK] && !flg_i[FI_SD] && !flg_i[FI_OT];
    drop      = flg_i[FI_VOFF] || flg_i[FI_LLOW] || flg_i[FI_SD];
    trip      = flg_i[FI_OT] || flg_i[FI_OC];
    mode_d    = mode_q;
    sd_seen_d = 1'b0;
    case (mode_q)
      MD_LOCK: begin
        if (start_ok) mode_d = MD_PRE;
      end
      MD_PRE: begin
        if (drop)                mode_d = MD_LOCK;
        else if (flg_i[FI_OT])   mode_d = MD_FLT;
        else if (ph_done_i)      mode_d = MD_IGN;
      end
      MD_IGN: begin
        if (drop)                mode_d = MD_LOCK;
        else if (trip)           mode_d = MD_FLT;
        else if (ignited_i)      mode_d = MD_DIM;
      end
      MD_DIM: begin
        if (drop)                mode_d = MD_LOCK;
        else if (trip)           mode_d = MD_FLT;
      end
      MD_FLT: begin
        sd_seen_d = sd_seen_q | flg_i[FI_SD];
        if (flg_i[FI_VOFF])                  mode_d = MD_LOCK;
        else if (sd_seen_q && !flg_i[FI_SD]) mode_d = MD_LOCK;
      end
      default: mode_d = MD_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_LOCK;
      sd_seen_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      sd_seen_q <= sd_seen_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
  import bsq_pkg::*;
#(
  parameter int PH_CYCLES   = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       supply_on_i,
  input  logic       supply_off_i,
  input  logic       line_ok_i,
  input  logic       line_low_i,
  input  logic       shutdown_i,
  input  logic       overtemp_i,
  input  logic       overcur_i,
  input  logic       sense_arm_i,
  input  logic       sense_det_i,
  output logic [2:0] mode_o,
  output logic       drv_en_o,
  output logic       oc_en_o,
  output logic       ref_hi_o
);

  logic              rst_n;
  logic [FLAG_N-1:0] flg_raw, flg_s;
  logic              ph_done, ignited;
  bsq_mode_e         mode;

  always_comb begin
    flg_raw          = '0;
    flg_raw[FI_VON]  = supply_on_i;
    flg_raw[FI_VOFF] = supply_off_i;
    flg_raw[FI_LOK]  = line_ok_i;
    flg_raw[FI_LLOW] = line_low_i;
    flg_raw[FI_SD]   = shutdown_i;
    flg_raw[FI_OT]   = overtemp_i;
    flg_raw[FI_OC]   = overcur_i;
    flg_raw[FI_ARM]  = sense_arm_i;
    flg_raw[FI_DET]  = sense_det_i;
  end

  bsq_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  bsq_sync #(.W(FLAG_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (flg_raw),
    .q_o   (flg_s)
  );

  bsq_timer #(.TERM(PH_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (mode != MD_PRE),
    .cnt_en_i (1'b1),
    .done_o   (ph_done)
  );

  bsq_ign_arm u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (mode != MD_IGN),
    .arm_lvl_i (flg_s[FI_ARM]),
    .det_lvl_i (flg_s[FI_DET]),
    .ignited_o (ignited)
  );

  bsq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .flg_i     (flg_s),
    .ph_done_i (ph_done),
    .ignited_i (ignited),
    .mode_o    (mode)
  );

  assign mode_o   = mode;
  assign drv_en_o = (mode == MD_PRE) || (mode == MD_IGN) || (mode == MD_DIM);
  assign oc_en_o  = (mode == MD_IGN) || (mode == MD_DIM);
  assign ref_hi_o = (mode == MD_IGN);

endmodule

// File: rtl/ballast_seq_chk.sv
module ballast_seq_chk (
  input logic       clk,
  input logic       arst_n,
  input logic [2:0] mode_o,
  input logic       drv_en_o,
  input logic       oc_en_o,
  input logic       ref_hi_o
);

  // R10
  mode_range_chk: assert property (@(posedge clk) disable iff (!arst_n)
    mode_o <= 3'd4);

  // R10
  drv_off_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_o == 3'd0 || mode_o == 3'd4) |-> !drv_en_o);

  // R5
  oc_pre_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_o == 3'd1) |-> !oc_en_o);

  // R8
  ref_pre_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_o == 3'd1) |-> !ref_hi_o);

  // R2
  lock_exit_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_o == 3'd0) |=> (mode_o == 3'd0 || mode_o == 3'd1));

  // R4
  ign_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_o != 3'd1 && mode_o != 3'd2) |=> (mode_o != 3'd2));

  // R7
  dim_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_o != 3'd2 && mode_o != 3'd3) |=> (mode_o != 3'd3));

  // R9
  flt_exit_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_o == 3'd4) |=> (mode_o == 3'd4 || mode_o == 3'd0));

endmodule

bind ballast_seq ballast_seq_chk u_chk (
  .clk      (clk),
  .arst_n   (arst_n),
  .mode_o   (mode_o),
  .drv_en_o (drv_en_o),
  .oc_en_o  (oc_en_o),
  .ref_hi_o (ref_hi_o)
);

// File: tb/ballast_seq_test.sv
`timescale 1ns/1ps
module ballast_seq_test;

  localparam int PH = 16;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic von = 1'b0, voff = 1'b1, lok = 1'b0, llow = 1'b1;
  logic sd = 1'b0, ot = 1'b0, oc = 1'b0, arm = 1'b0, det = 1'b0;
  logic [2:0] mode_o;
  logic drv_en_o, oc_en_o, ref_hi_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ballast_seq #(.PH_CYCLES(PH)) uut (
    .clk          (clk),
    .arst_n       (arst_n),
    .supply_on_i  (von),
    .supply_off_i (voff),
    .line_ok_i    (lok),
    .line_low_i   (llow),
    .shutdown_i   (sd),
    .overtemp_i   (ot),
    .overcur_i    (oc),
    .sense_arm_i  (arm),
    .sense_det_i  (det),
    .mode_o       (mode_o),
    .drv_en_o     (drv_en_o),
    .oc_en_o      (oc_en_o),
    .ref_hi_o     (ref_hi_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model (R11 latency: two sample stages, then mode).
  int   m_st = 0, m_cnt = 0, m_rc = 0;
  bit   m_arm = 0, m_sds = 0;
  bit   m_s1 [9];
  bit   m_s2 [9];

  always @(posedge clk) begin
    int nst;
    bit cur [9];
    cur = '{von, voff, lok, llow, sd, ot, oc, arm, det};
    if (!arst_n || m_rc < 2) begin
      if (!arst_n) m_rc = 0; else m_rc++;
      m_st = 0; m_cnt = 0; m_arm = 0; m_sds = 0;
      m_s1 = '{default: 0}; m_s2 = '{default: 0};
    end else begin
      nst = m_st;
      case (m_st)
        0: if (m_s2[0] && m_s2[2] && !m_s2[4] && !m_s2[5]) nst = 1;
        1, 2, 3: begin
          if (m_s2[1] || m_s2[3] || m_s2[4]) nst = 0;
          else if (m_s2[5] || (m_st != 1 && m_s2[6])) nst = 4;
          else if (m_st == 1 && m_cnt == PH - 1) nst = 2;
          else if (m_st == 2 && m_arm && m_s2[8]) nst = 3;
        end
        default: if (m_s2[1] || (m_sds && !m_s2[4])) nst = 0;
      endcase
      m_cnt = (m_st == 1) ? m_cnt + 1 : 0;
      m_arm = (m_st == 2) ? (m_arm | m_s2[7]) : 1'b0;
      m_sds = (m_st == 4) ? (m_sds | m_s2[4]) : 1'b0;
      m_s2 = m_s1;
      m_s1 = cur;
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(mode_o == 3'(m_st), "R10 mode vs model", int'(mode_o), m_st);
      chk(drv_en_o == (m_st >= 1 && m_st <= 3), "R10 drv_en vs model",
          int'(drv_en_o), int'(m_st >= 1 && m_st <= 3));
      chk(oc_en_o == (m_st == 2 || m_st == 3), "R5 oc_en vs model",
          int'(oc_en_o), int'(m_st == 2 || m_st == 3));
      chk(ref_hi_o == (m_st == 2), "R8 ref_hi vs model",
          int'(ref_hi_o), int'(m_st == 2));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_mode(input int m, input string tag);
    for (int i = 0; i < 300 && mode_o != 3'(m); i++) step(1);
    chk(mode_o == 3'(m), tag, int'(mode_o), m);
  endtask

  task automatic supply_good();
    von = 1; voff = 0; lok = 1; llow = 0;
  endtask

  initial begin
    int n;
    step(3);
    arst_n = 1'b1;
    step(1);
    chk(mode_o == 3'd0, "R1 reset mode", int'(mode_o), 0);
    chk(!drv_en_o && !oc_en_o && !ref_hi_o, "R1 reset outputs",
        int'({drv_en_o, oc_en_o, ref_hi_o}), 0);
    step(3);

    // R2: start blocked by shutdown, then by over-temperature
    supply_good(); sd = 1;
    step(6);
    chk(mode_o == 3'd0, "R2 held by shutdown", int'(mode_o), 0);
    sd = 0; ot = 1;
    step(6);
    chk(mode_o == 3'd0, "R2 held by overtemp", int'(mode_o), 0);
    ot = 0;
    step(2);
    chk(mode_o == 3'd0, "R11 no change after two edges", int'(mode_o), 0);
    step(1);
    chk(mode_o == 3'd1, "R2 enter preheat", int'(mode_o), 1);

    // R4 / R5: preheat length with an over-current pulse inside it
    n = 1;
    oc = 1;
    for (int i = 0; i < 5; i++) begin step(1); if (mode_o == 3'd1) n++; end
    chk(mode_o == 3'd1, "R5 overcur ignored in preheat", int'(mode_o), 1);
    oc = 0;
    for (int i = 0; i < 200 && mode_o == 3'd1; i++) begin step(1); if (mode_o == 3'd1) n++; end
    chk(n == PH, "R4 preheat length", n, PH);
    chk(mode_o == 3'd2, "R4 ignition after preheat", int'(mode_o), 2);
    chk(ref_hi_o == 1'b1, "R8 fixed reference in ignition", int'(ref_hi_o), 1);

    // R7: detect without arming does nothing; then arm and detect
    det = 1;
    step(6);
    chk(mode_o == 3'd2, "R7 unarmed detect ignored", int'(mode_o), 2);
    det = 0; arm = 1;
    step(2);
    arm = 0;
    step(3);
    chk(mode_o == 3'd2, "R7 armed, no detect yet", int'(mode_o), 2);
    det = 1;
    step(4);
    chk(mode_o == 3'd3, "R7 enter dim", int'(mode_o), 3);
    det = 0;

    // R6 / R9: over-current in dim, hold, shutdown toggle release
    oc = 1;
    step(4);
    chk(mode_o == 3'd4, "R6 overcur in dim", int'(mode_o), 4);
    chk(drv_en_o == 1'b0, "R9 drivers off in fault", int'(drv_en_o), 0);
    oc = 0;
    step(10);
    chk(mode_o == 3'd4, "R9 fault held", int'(mode_o), 4);
    sd = 1;
    step(5);
    chk(mode_o == 3'd4, "R9 fault held while shutdown high", int'(mode_o), 4);
    sd = 0;
    step(3);
    chk(mode_o == 3'd0, "R9 release to lockout", int'(mode_o), 0);
    step(1);
    chk(mode_o == 3'd1, "R9 restart in preheat", int'(mode_o), 1);

    // R6 / R9: over-temperature in ignition, supply dip release
    wait_mode(2, "R4 ignition again");
    ot = 1;
    step(4);
    chk(mode_o == 3'd4, "R6 overtemp in ignition", int'(mode_o), 4);
    ot = 0;
    voff = 1; von = 0;
    step(4);
    chk(mode_o == 3'd0, "R9 supply dip clears fault", int'(mode_o), 0);
    step(4);
    chk(mode_o == 3'd0, "R2 stays in lockout on low supply", int'(mode_o), 0);

    // R6: over-temperature in preheat
    supply_good();
    wait_mode(1, "R2 restart preheat");
    ot = 1;
    step(4);
    chk(mode_o == 3'd4, "R6 overtemp in preheat", int'(mode_o), 4);
    ot = 0; sd = 1;
    step(3);
    sd = 0;
    wait_mode(2, "R9 restart reaches ignition");
    arm = 1;
    step(3);
    arm = 0; det = 1;
    wait_mode(3, "R7 dim again");
    det = 0;

    // R3: brown-out in dim, shutdown in preheat
    lok = 0; llow = 1;
    step(4);
    chk(mode_o == 3'd0, "R3 brown-out from dim", int'(mode_o), 0);
    chk(drv_en_o == 1'b0, "R3 drivers off after brown-out", int'(drv_en_o), 0);
    supply_good();
    wait_mode(1, "R2 start after line recovers");
    sd = 1;
    step(4);
    chk(mode_o == 3'd0, "R3 shutdown from preheat", int'(mode_o), 0);
    sd = 0;
    step(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule